// File: doc/BRIEF.md
# Nibble-Addressed Register Command Port

This block is the device end of a byte-stream link through which a host reaches a small internal register file. Each incoming byte carries a 4-bit opcode in its upper half and a 4-bit payload in its lower half. Because every command holds only one nibble, the host builds an 8-bit register address from two commands and sends each data byte as two commands. Read commands return one byte on an outgoing byte stream. A variant of the read advances the address afterwards, so adjacent registers can be walked in a single burst.

The low addresses hold the latched trigger and stop positions of a capture engine, as two 24-bit values. A mode register starts and stops capture and enables readout of the sample memory. The remaining addresses are plain read/write storage. Out of reset the block sends a fixed three-byte identification reply before it accepts any command.

The trigger and stop positions are copied into a shadow register when their first byte is read. A six-byte burst therefore returns a coherent pair, even while the live counters keep moving.

Top module: `regcmd_port`

## Requirements
- R1: After reset the block sends the bytes 0xA6, 0x55, 0xAA in that order on the reply stream. It accepts no command (cmd_ready_o low) until all three bytes have been taken.
- R2: Opcode 0x0 (input bits 7:4) replaces address bits 3:0 with the payload (input bits 3:0). Opcode 0x1 replaces address bits 7:4. Each leaves the other nibble unchanged.
- R3: Opcode 0x2 stores the payload as a pending low data nibble. Opcode 0x3 writes {payload, pending low nibble} to the current address and then adds one to the address.
- R4: Opcode 0x4 returns the contents of the current register as one reply byte and leaves the address unchanged.
- R5: Opcode 0x5 returns the current register and then adds one to the address, wrapping from 0xFF to 0x00.
- R6: Addresses 0 to 2 read the trigger position and addresses 3 to 5 read the stop position, each least-significant byte first. A read of address 0 returns the live trigger low byte and copies both positions into a shadow that addresses 1 to 5 return. Writes to addresses 0 to 5 have no effect.
- R7: At address 6, writing 0x0D sets capture_o and clears readout_o. Writing 0x11 clears capture_o. Writing 0x02 sets readout_o and clears capture_o. Any other value changes nothing. A read of address 6 returns capture_o in bit 0, readout_o in bit 1, trig_fired_i in bit 5, and zeros elsewhere.
- R8: While a reply byte is pending, cmd_ready_o is low and rsp_data_o holds steady until rsp_ready_i takes the byte.
- R9: Opcodes 0x6 to 0xF are accepted and ignored: no reply, no change to the address or to the pending data nibble.
- R10: Addresses 7 to NREGS-1 (default 15) are read/write storage that resets to 0x00. Addresses from NREGS upward read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_data_i | input | 8 | Command byte: opcode in bits 7:4, payload in bits 3:0 |
| cmd_ready_o | output | 1 | Command byte accepted on this edge when valid is also high |
| rsp_valid_o | output | 1 | Reply byte valid |
| rsp_data_o | output | 8 | Reply byte |
| rsp_ready_i | input | 1 | Host takes the reply byte |
| trig_pos_i | input | 24 | Live trigger position |
| stop_pos_i | input | 24 | Live stop position |
| trig_fired_i | input | 1 | Trigger has fired, reported in mode status bit 5 |
| capture_o | output | 1 | Capture running |
| readout_o | output | 1 | Sample-memory readout enabled |

## Verification
Command streams that split address and data nibbles across separate commands show whether each nibble lands in its own half and whether the pending low data nibble survives ignored opcodes. Plain reads and auto-increment reads sent to the same address show the difference between the two opcodes. Reads near 0xFF show both the address wrap and the out-of-range reads of zero. A six-byte position burst is run while the live counters change in mid-burst, which separates a coherent snapshot from a live readback. Mode writes with valid and invalid values, together with stalled reply hand-offs, cover the control outputs and the backpressure on the command stream.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  typedef enum logic [3:0] {
    OP_ADDR_LO   = 4'h0,
    OP_ADDR_HI   = 4'h1,
    OP_DATA_LO   = 4'h2,
    OP_DATA_HI   = 4'h3,
    OP_READ      = 4'h4,
    OP_READ_NEXT = 4'h5
  } opcode_e;

  localparam logic [7:0] ID_B0 = 8'hA6;
  localparam logic [7:0] ID_B1 = 8'h55;
  localparam logic [7:0] ID_B2 = 8'hAA;

  localparam logic [7:0] MODE_RUN      = 8'h0D;
  localparam logic [7:0] MODE_HALT     = 8'h11;
  localparam logic [7:0] MODE_READOUT  = 8'h02;
  localparam int         STAT_TRIG_BIT = 5;

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    id_byte = ID_B0;
      2'd1:    id_byte = ID_B1;
      default: id_byte = ID_B2;
    endcase
  endfunction
endpackage

// File: rtl/regcmd_decode.sv
module regcmd_decode
  import regcmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int NIB = 4;

  logic [ADDR_W-1:0] addr_q;
  logic [NIB-1:0]    dlo_q;
  opcode_e           op;
  logic [NIB-1:0]    pl;

  assign op = opcode_e'(byte_i[7:4]);
  assign pl = byte_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dlo_q  <= '0;
    end else if (take_i) begin
      case (op)
        OP_ADDR_LO:   addr_q[NIB-1:0]      <= pl;
        OP_ADDR_HI:   addr_q[ADDR_W-1:NIB] <= pl;
        OP_DATA_LO:   dlo_q                <= pl;
        OP_DATA_HI,
        OP_READ_NEXT: addr_q               <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign wr_en_o   = take_i && (op == OP_DATA_HI);
  assign wr_addr_o = addr_q;
  assign wr_data_o = {pl, dlo_q};
  assign rd_en_o   = take_i && ((op == OP_READ) || (op == OP_READ_NEXT));
  assign rd_addr_o = addr_q;
endmodule

// File: rtl/regcmd_regs.sv
module regcmd_regs
  import regcmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int POS_W  = 24,
  parameter int NREGS  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [POS_W-1:0]  trig_pos_i,
  input  logic [POS_W-1:0]  stop_pos_i,
  input  logic              trig_fired_i,
  output logic              capture_o,
  output logic              readout_o
);
  localparam int POS_N    = 2 * (POS_W / 8);
  localparam int MODE_IDX = POS_N;
  localparam int SCR_BASE = POS_N + 1;
  localparam int NSCR     = NREGS - SCR_BASE;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_IDX);

  logic [2*POS_W-1:0] live, snap_q;
  logic [7:0]         scr_q [NSCR];
  logic               capture_q, readout_q;

  assign live = {stop_pos_i, trig_pos_i};

  // snapshot on the burst's first byte keeps all six bytes coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (rd_en_i && rd_addr_i == '0) snap_q <= live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capture_q <= 1'b0;
      readout_q <= 1'b0;
    end else if (wr_en_i && wr_addr_i == MODE_ADDR) begin
      case (wr_data_i)
        MODE_RUN:     begin capture_q <= 1'b1; readout_q <= 1'b0; end
        MODE_HALT:    capture_q <= 1'b0;
        MODE_READOUT: begin capture_q <= 1'b0; readout_q <= 1'b1; end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NSCR; g++) begin : g_scr
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SCR_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scr_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == MY_ADDR) scr_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o = live[7:0];
    for (int b = 1; b < POS_N; b++)
      if (rd_addr_i == ADDR_W'(b)) rd_data_o = snap_q[8*b +: 8];
    if (rd_addr_i == MODE_ADDR) begin
      rd_data_o[0]             = capture_q;
      rd_data_o[1]             = readout_q;
      rd_data_o[STAT_TRIG_BIT] = trig_fired_i;
    end
    for (int s = 0; s < NSCR; s++)
      if (rd_addr_i == ADDR_W'(SCR_BASE + s)) rd_data_o = scr_q[s];
  end

  assign capture_o = capture_q;
  assign readout_o = readout_q;
endmodule

// File: rtl/regcmd_resp.sv
module regcmd_resp
  import regcmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  logic [7:0] rd_data_i,
  input  logic       rsp_ready_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o
);
  logic [1:0] id_cnt_q;
  logic       id_done_q;
  logic       valid_q;
  logic [7:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b1;
      data_q    <= ID_B0;
      id_cnt_q  <= 2'd1;
      id_done_q <= 1'b0;
    end else if (valid_q && rsp_ready_i) begin
      if (!id_done_q && id_cnt_q != 2'd3) begin
        data_q   <= id_byte(id_cnt_q);
        id_cnt_q <= id_cnt_q + 2'd1;
      end else begin
        valid_q   <= 1'b0;
        id_done_q <= 1'b1;
      end
    end else if (rd_en_i) begin
      valid_q <= 1'b1;
      data_q  <= rd_data_i;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_data_o  = data_q;
endmodule

// File: rtl/regcmd_port.sv
module regcmd_port #(
  parameter int ADDR_W = 8,
  parameter int POS_W  = 24,
  parameter int NREGS  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_data_i,
  output logic             cmd_ready_o,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_data_o,
  input  logic             rsp_ready_i,
  input  logic [POS_W-1:0] trig_pos_i,
  input  logic [POS_W-1:0] stop_pos_i,
  input  logic             trig_fired_i,
  output logic             capture_o,
  output logic             readout_o
);
  logic              take;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  // one reply slot: stall commands while it is occupied
  assign cmd_ready_o = !rsp_valid_o;
  assign take        = cmd_valid_i && cmd_ready_o;

  regcmd_decode #(.ADDR_W(ADDR_W), .DATA_W(8)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .byte_i    (cmd_data_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr)
  );

  regcmd_regs #(.ADDR_W(ADDR_W), .POS_W(POS_W), .NREGS(NREGS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .rd_en_i      (rd_en),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .trig_pos_i   (trig_pos_i),
    .stop_pos_i   (stop_pos_i),
    .trig_fired_i (trig_fired_i),
    .capture_o    (capture_o),
    .readout_o    (readout_o)
  );

  regcmd_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en),
    .rd_data_i   (rd_data),
    .rsp_ready_i (rsp_ready_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: rtl/regcmd_port_chk.sv
module regcmd_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_data_i,
  input logic       cmd_ready_o,
  input logic       rsp_valid_o,
  input logic [7:0] rsp_data_o,
  input logic       rsp_ready_i,
  input logic       capture_o,
  input logic       readout_o
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  assert_hold_reply_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  assert_stall_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);

  assert_read_replies_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (cmd_data_i[7:4] == 4'h4 || cmd_data_i[7:4] == 4'h5)) |=> rsp_valid_o);

  assert_unknown_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_data_i[7:4] >= 4'h6) |=> !rsp_valid_o);

  assert_mode_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_o && readout_o));
endmodule

bind regcmd_port regcmd_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_data_i  (cmd_data_i),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .rsp_ready_i (rsp_ready_i),
  .capture_o   (capture_o),
  .readout_o   (readout_o)
);

// File: tb/regcmd_port_tb.sv
`timescale 1ns/1ps
module regcmd_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_data_i = '0;
  logic        cmd_ready_o, rsp_valid_o, rsp_ready_i = 1'b0;
  logic [7:0]  rsp_data_o;
  logic [23:0] trig_pos_i = 24'h123456, stop_pos_i = 24'hABCDEF;
  logic        trig_fired_i = 1'b0;
  logic        capture_o, readout_o;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  regcmd_port u_dut (.*);

  // {req tag number, expect reply, command, expected reply}
  localparam int NV = 28;
  localparam logic [20:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'h07, 8'h00},  // R2 addr lo 7
    {4'd2, 1'b0, 8'h10, 8'h00},  // R2 addr hi 0 -> 0x07
    {4'd3, 1'b0, 8'h2A, 8'h00},  // R3
    {4'd3, 1'b0, 8'h35, 8'h00},  // R3 write 0x5A @7 -> 8
    {4'd3, 1'b0, 8'h23, 8'h00},
    {4'd3, 1'b0, 8'h3C, 8'h00},  // R3 write 0xC3 @8 -> 9
    {4'd2, 1'b0, 8'h07, 8'h00},  // R2 only low nibble -> 0x07
    {4'd5, 1'b1, 8'h50, 8'h5A},  // R5 read-next -> 8
    {4'd4, 1'b1, 8'h40, 8'hC3},  // R4
    {4'd4, 1'b1, 8'h40, 8'hC3},  // R4 address unchanged
    {4'd9, 1'b0, 8'h9F, 8'h00},  // R9 ignored
    {4'd3, 1'b0, 8'h2F, 8'h00},  // R3 pending low F
    {4'd9, 1'b0, 8'h7E, 8'h00},  // R9 ignored
    {4'd9, 1'b1, 8'h40, 8'hC3},  // R9 address still 8
    {4'd9, 1'b0, 8'h31, 8'h00},  // R9 write 0x1F @8: low nibble survived
    {4'd3, 1'b0, 8'h08, 8'h00},
    {4'd3, 1'b1, 8'h40, 8'h1F},  // R3
    {4'd2, 1'b0, 8'h1F, 8'h00},  // R2 hi F -> 0xF8
    {4'd2, 1'b0, 8'h0F, 8'h00},  // -> 0xFF
    {4'd10,1'b1, 8'h50, 8'h00},  // R10 out of range, wrap to 0
    {4'd5, 1'b1, 8'h40, 8'h56},  // R5 wrapped to 0: trig low byte
    {4'd10,1'b0, 8'h0F, 8'h00},
    {4'd10,1'b0, 8'h1F, 8'h00},  // addr 0xFF
    {4'd10,1'b0, 8'h27, 8'h00},
    {4'd10,1'b0, 8'h37, 8'h00},  // R10 write 0x77 @0xFF ignored
    {4'd10,1'b0, 8'h0F, 8'h00},
    {4'd10,1'b0, 8'h1F, 8'h00},
    {4'd10,1'b1, 8'h40, 8'h00}   // R10 still reads 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    cmd_valid_i = 1'b1;
    cmd_data_i  = b;
    while (!cmd_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic take(output logic [7:0] v);
    rsp_ready_i = 1'b1;
    while (!rsp_valid_o) @(negedge clk_i);
    v = rsp_data_o;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] op, input string req, input logic [7:0] exp);
    logic [7:0] v;
    send(op);
    take(v);
    check(req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    set_addr(a);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 ready", {31'h0, cmd_ready_o}, 32'h0);
    check("R1 valid", {31'h0, rsp_valid_o}, 32'h1);
    cmd_valid_i = 1'b1; cmd_data_i = 8'h40;
    repeat (3) @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check("R1 held", {24'h0, rsp_data_o}, 32'hA6);
    check("R8 stall", {31'h0, cmd_ready_o}, 32'h0);
    take(v); check("R1 b0", {24'h0, v}, 32'hA6);
    take(v); check("R1 b1", {24'h0, v}, 32'h55);
    take(v); check("R1 b2", {24'h0, v}, 32'hAA);
    check("R1 done", {30'h0, rsp_valid_o, cmd_ready_o}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][15:8]);
      if (VEC[i][16]) begin
        take(v);
        check($sformatf("R%0d vec%0d", VEC[i][20:17], i), {24'h0, v}, {24'h0, VEC[i][7:0]});
      end else begin
        check($sformatf("R%0d vec%0d silent", VEC[i][20:17], i), {31'h0, rsp_valid_o}, 32'h0);
      end
    end

    // R6 coherent burst
    set_addr(8'h00);
    rd(8'h50, "R6 t0", 8'h56);
    trig_pos_i = 24'h999999; stop_pos_i = 24'h777777;
    rd(8'h50, "R6 t1", 8'h34);
    rd(8'h50, "R6 t2", 8'h12);
    rd(8'h50, "R6 s0", 8'hEF);
    rd(8'h50, "R6 s1", 8'hCD);
    rd(8'h50, "R6 s2", 8'hAB);
    set_addr(8'h00);
    rd(8'h50, "R6 new t0", 8'h99);
    rd(8'h50, "R6 new s0 skip", 8'h99);
    wr(8'h01, 8'hFF);
    set_addr(8'h01);
    rd(8'h40, "R6 write ignored", 8'h99);

    // R7 mode
    wr(8'h06, 8'h0D);
    check("R7 run", {30'h0, capture_o, readout_o}, 32'h2);
    trig_fired_i = 1'b1;
    set_addr(8'h06);
    rd(8'h40, "R7 status run", 8'h21);
    wr(8'h06, 8'h33);
    check("R7 bad value", {30'h0, capture_o, readout_o}, 32'h2);
    wr(8'h06, 8'h02);
    check("R7 readout", {30'h0, capture_o, readout_o}, 32'h1);
    set_addr(8'h06);
    rd(8'h40, "R7 status readout", 8'h22);
    wr(8'h06, 8'h0D);
    wr(8'h06, 8'h11);
    trig_fired_i = 1'b0;
    check("R7 halt", {30'h0, capture_o, readout_o}, 32'h0);
    set_addr(8'h06);
    rd(8'h40, "R7 status idle", 8'h00);

    // R8 reply held under backpressure
    wr(8'h0F, 8'h6B);
    set_addr(8'h0F);
    send(8'h40);
    held = rsp_data_o;
    repeat (4) @(negedge clk_i);
    check("R8 ready low", {31'h0, cmd_ready_o}, 32'h0);
    check("R8 stable", {24'h0, rsp_data_o}, {24'h0, held});
    take(v);
    check("R8 data R10", {24'h0, v}, 32'h6B);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule